// File: doc/BRIEF.md
# Accumulator Fetch-Execute Sequencer

This block is a small 8-bit accumulator processor. It is built to make every register transfer visible. It holds a program counter, an instruction register, a memory address register, a memory data register, an accumulator and a carry flag. It also contains a 32-word memory that serves as both program and data store. Each instruction runs through the same fixed chain of one-clock transfers:

1. The address register is loaded from the program counter.
2. Memory is read into the data register.
3. The instruction register is filled from the data register.
4. The operand address is copied into the address register.
5. The data access takes place.
6. The operation completes.
7. The program counter advances.

An instruction byte carries a 3-bit opcode in bits [7:5] and a 5-bit direct memory address in bits [4:0]. The supported opcodes are load, store and add. A halt opcode stops the machine, and every other opcode does nothing except advance the program counter.

The memory is filled through a preload port while reset is held. After reset is released, the sequencer starts fetching at address 0. Debug outputs carry every register and the one-hot step register. This lets a bench or a debug probe follow the machine clock by clock.

Top module: `acc_seq_core`

## Requirements
- R1: An active-high synchronous reset sets the program counter, instruction register, address register, data register, accumulator and carry flag to zero, and sets the step output to 8'b0000_0001.
- R2: The step output is always one-hot, with bit0 fetch-address, bit1 fetch-read, bit2 fetch-decode, bit3 operand-address, bit4 data-access, bit5 complete, bit6 advance and bit7 halted. Outside reset and halt, it moves from bit0 to bit6 one bit per clock and then returns to bit0.
- R3: In the fetch steps, the address register takes the program counter, then the data register takes memory at that address, then the instruction register takes the data register.
- R4: An instruction's bits [7:5] are its opcode and bits [4:0] are its operand address. In the operand-address step, the address register takes bits [4:0] of the instruction register.
- R5: Opcode 3'b010 (load) places the memory word at the operand address in the accumulator.
- R6: Opcode 3'b101 (add) sets the accumulator to (accumulator + memory word) mod 256, and sets the carry flag to the carry out of bit 7.
- R7: Opcode 3'b011 (store) copies the accumulator into the data register and writes it to the operand address. The accumulator and carry are left unchanged.
- R8: Opcode 3'b111 (halt) moves the step output from the operand-address step to 8'b1000_0000. The machine then stays there with every register frozen until reset.
- R9: Opcodes 3'b000, 3'b001, 3'b100 and 3'b110 leave the accumulator, carry and memory unchanged, and only advance the program counter.
- R10: The program counter rises by exactly one per completed instruction, in the advance step only, and wraps from 31 to 0.
- R11: With word 6 = 8'b0100_1111, word 15 = 10, word 7 = 8'b1011_0010 and word 18 = 71, the accumulator is 8'b0000_1010 after the instruction at 6 and 8'b0101_0001 after the instruction at 7.
- R12: The carry flag changes only in the complete step of an add.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high synchronous reset |
| load_en | input | 1 | Preload write strobe for the memory |
| load_addr | input | 5 | Preload word address |
| load_data | input | 8 | Preload word value |
| dbg_pc | output | 5 | Program counter |
| dbg_ir | output | 8 | Instruction register |
| dbg_mar | output | 5 | Memory address register |
| dbg_mdr | output | 8 | Memory data register |
| dbg_acc | output | 8 | Accumulator |
| dbg_carry | output | 1 | Carry flag from the last add |
| dbg_step | output | 8 | One-hot current step |

## Verification
The embedded properties assume that reset is high at the first clock edge. They also assume that preload writes arrive only while reset is held. A preload strobe during a run would change memory behind the sequencer and would pre-empt a store write. The stimulus therefore fills all 32 words before every program while reset stays asserted, so no read ever sees an unwritten word. Reset is raised in the middle of an instruction only once, to exercise R1, and the strobe stays low throughout.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;
  localparam int OP_W = 3;

  localparam logic [OP_W-1:0] OPC_LOAD  = 3'b010;
  localparam logic [OP_W-1:0] OPC_STORE = 3'b011;
  localparam logic [OP_W-1:0] OPC_ADD   = 3'b101;
  localparam logic [OP_W-1:0] OPC_HALT  = 3'b111;

  // one-hot step positions, in execution order
  localparam int ST_FADDR = 0;
  localparam int ST_FREAD = 1;
  localparam int ST_FDEC  = 2;
  localparam int ST_OADDR = 3;
  localparam int ST_DACC  = 4;
  localparam int ST_DONE  = 5;
  localparam int ST_ADV   = 6;
  localparam int ST_HALT  = 7;
  localparam int NSTEPS   = 8;
endpackage

// File: rtl/acc_seq_mem.sv
module acc_seq_mem #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  // the word is captured by the data register on the next edge
  assign rdata = cells[raddr];
endmodule

// File: rtl/acc_seq_ctrl.sv
module acc_seq_ctrl
  import acc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              halt_req,
  output logic [NSTEPS-1:0] step
);
  localparam logic [NSTEPS-1:0] STEP_FIRST = NSTEPS'(1) << ST_FADDR;
  localparam logic [NSTEPS-1:0] STEP_HALT  = NSTEPS'(1) << ST_HALT;

  logic [NSTEPS-1:0] step_nxt;
  logic              enter_halt;

  assign enter_halt = step[ST_OADDR] && halt_req;

  always_comb begin
    if (step[ST_HALT])      step_nxt = step;
    else if (enter_halt)    step_nxt = STEP_HALT;
    else if (step[ST_ADV])  step_nxt = STEP_FIRST;
    else                    step_nxt = step << 1;
  end

  always_ff @(posedge clk) begin
    if (rst) step <= STEP_FIRST;
    else     step <= step_nxt;
  end

  assert_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(step) == 1);

  for (genvar gi = ST_FADDR; gi < ST_ADV; gi++) begin : g_order
    assert_order_R2: assert property (@(posedge clk) disable iff (rst)
      (step[gi] && !(gi == ST_OADDR && halt_req)) |=> step[gi+1]);
  end

  assert_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    step[ST_ADV] |=> step[ST_FADDR]);

  assert_halt_entry_R8: assert property (@(posedge clk) disable iff (rst)
    enter_halt |=> step[ST_HALT]);

  assert_halt_stays_R8: assert property (@(posedge clk) disable iff (rst)
    step[ST_HALT] |=> step[ST_HALT]);
endmodule

// File: rtl/acc_seq_datapath.sv
module acc_seq_datapath
  import acc_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSTEPS-1:0] step,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] ir,
  output logic [ADDR_W-1:0] mar,
  output logic [DATA_W-1:0] mdr,
  output logic [DATA_W-1:0] acc,
  output logic              carry,
  output logic              store_we,
  output logic              halt_req
);
  localparam logic [ADDR_W-1:0] PC_ONE = ADDR_W'(1);

  function automatic logic [DATA_W:0] add_wide(input logic [DATA_W-1:0] a,
                                               input logic [DATA_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  // named events for the properties below
  logic [OP_W-1:0] op;
  logic            is_load, is_store, is_add, is_nop;
  logic            ev_load, ev_add, ev_nop;
  logic [DATA_W:0] sum;

  assign op       = ir[DATA_W-1 -: OP_W];
  assign is_load  = (op == OPC_LOAD);
  assign is_store = (op == OPC_STORE);
  assign is_add   = (op == OPC_ADD);
  assign halt_req = (op == OPC_HALT);
  assign is_nop   = !(is_load || is_store || is_add || halt_req);
  assign ev_load  = step[ST_DONE] && is_load;
  assign ev_add   = step[ST_DONE] && is_add;
  assign ev_nop   = step[ST_DONE] && is_nop;
  assign store_we = step[ST_DONE] && is_store;
  assign sum      = add_wide(acc, mdr);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc    <= '0;
      ir    <= '0;
      mar   <= '0;
      mdr   <= '0;
      acc   <= '0;
      carry <= 1'b0;
    end else begin
      if (step[ST_FADDR]) mar <= pc;
      if (step[ST_FREAD]) mdr <= mem_rdata;
      if (step[ST_FDEC])  ir  <= mdr;
      if (step[ST_OADDR]) mar <= ir[ADDR_W-1:0];
      if (step[ST_DACC]) begin
        if (is_load || is_add) mdr <= mem_rdata;
        else if (is_store)     mdr <= acc;
      end
      if (ev_load) acc <= mdr;
      if (ev_add)  {carry, acc} <= sum;
      if (step[ST_ADV]) pc <= pc + PC_ONE;
    end
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (pc == '0 && ir == '0 && mar == '0 && mdr == '0 && acc == '0 && !carry));

  assert_fetch_mar_R3: assert property (@(posedge clk) disable iff (rst)
    step[ST_FADDR] |=> mar == $past(pc));

  assert_fetch_ir_R3: assert property (@(posedge clk) disable iff (rst)
    step[ST_FDEC] |=> ir == $past(mdr));

  assert_operand_mar_R4: assert property (@(posedge clk) disable iff (rst)
    step[ST_OADDR] |=> mar == $past(ir[ADDR_W-1:0]));

  assert_load_acc_R5: assert property (@(posedge clk) disable iff (rst)
    ev_load |=> acc == $past(mdr));

  assert_add_sum_R6: assert property (@(posedge clk) disable iff (rst)
    ev_add |=> {carry, acc} == ({1'b0, $past(acc)} + {1'b0, $past(mdr)}));

  assert_store_keeps_acc_R7: assert property (@(posedge clk) disable iff (rst)
    store_we |=> ($stable(acc) && $stable(carry)));

  assert_halt_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    step[ST_HALT] |=> ($stable(pc) && $stable(acc) && $stable(ir) && $stable(mdr)));

  assert_nop_keeps_acc_R9: assert property (@(posedge clk) disable iff (rst)
    ev_nop |=> ($stable(acc) && $stable(carry)));

  assert_pc_step_R10: assert property (@(posedge clk) disable iff (rst)
    step[ST_ADV] |=> pc == $past(pc) + PC_ONE);

  assert_pc_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !step[ST_ADV] |=> $stable(pc));

  assert_carry_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !ev_add |=> $stable(carry));
endmodule

// File: rtl/acc_seq_core.sv
module acc_seq_core
  import acc_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [DATA_W-1:0] load_data,
  output logic [ADDR_W-1:0] dbg_pc,
  output logic [DATA_W-1:0] dbg_ir,
  output logic [ADDR_W-1:0] dbg_mar,
  output logic [DATA_W-1:0] dbg_mdr,
  output logic [DATA_W-1:0] dbg_acc,
  output logic              dbg_carry,
  output logic [NSTEPS-1:0] dbg_step
);
  logic [NSTEPS-1:0] step;
  logic              halt_req, store_we, mem_we;
  logic [ADDR_W-1:0] pc, mar, mem_waddr;
  logic [DATA_W-1:0] ir, mdr, acc, mem_rdata, mem_wdata;
  logic              carry;

  // preload has priority over a store commit
  assign mem_we    = load_en || store_we;
  assign mem_waddr = load_en ? load_addr : mar;
  assign mem_wdata = load_en ? load_data : mdr;

  acc_seq_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .halt_req (halt_req),
    .step     (step)
  );

  acc_seq_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .step      (step),
    .mem_rdata (mem_rdata),
    .pc        (pc),
    .ir        (ir),
    .mar       (mar),
    .mdr       (mdr),
    .acc       (acc),
    .carry     (carry),
    .store_we  (store_we),
    .halt_req  (halt_req)
  );

  acc_seq_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (mar),
    .rdata (mem_rdata)
  );

  assign dbg_pc    = pc;
  assign dbg_ir    = ir;
  assign dbg_mar   = mar;
  assign dbg_mdr   = mdr;
  assign dbg_acc   = acc;
  assign dbg_carry = carry;
  assign dbg_step  = step;

  assert_store_write_R7: assert property (@(posedge clk) disable iff (rst)
    store_we |-> (mem_we && mem_waddr == mar && mem_wdata == acc));
endmodule

// File: tb/acc_seq_core_test.sv
module acc_seq_core_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load_en = 1'b0;
  logic [4:0] load_addr = '0;
  logic [7:0] load_data = '0;
  logic [4:0] dbg_pc, dbg_mar;
  logic [7:0] dbg_ir, dbg_mdr, dbg_acc, dbg_step;
  logic       dbg_carry;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit finished = 0;
  bit cmp_on   = 0;

  // reference model state
  int m_pc, m_ir, m_mar, m_mdr, m_acc, m_c, m_st;
  int m_mem [32];

  always #4 clk = ~clk;

  acc_seq_core uut (
    .clk(clk), .rst(rst), .load_en(load_en), .load_addr(load_addr),
    .load_data(load_data), .dbg_pc(dbg_pc), .dbg_ir(dbg_ir),
    .dbg_mar(dbg_mar), .dbg_mdr(dbg_mdr), .dbg_acc(dbg_acc),
    .dbg_carry(dbg_carry), .dbg_step(dbg_step)
  );

  task automatic check_eq(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // behavioural model, advanced on the same edge as the design
  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_pc = 0; m_ir = 0; m_mar = 0; m_mdr = 0; m_acc = 0; m_c = 0; m_st = 0;
    end else begin
      int opc;
      int s;
      opc = m_ir / 32;
      case (m_st)
        0: begin m_mar = m_pc; m_st = 1; end
        1: begin m_mdr = m_mem[m_mar]; m_st = 2; end
        2: begin m_ir = m_mdr; m_st = 3; end
        3: begin m_mar = m_ir % 32; m_st = (opc == 7) ? 7 : 4; end
        4: begin
             if (opc == 2 || opc == 5) m_mdr = m_mem[m_mar];
             else if (opc == 3) m_mdr = m_acc;
             m_st = 5;
           end
        5: begin
             if (opc == 2) m_acc = m_mdr;
             if (opc == 5) begin s = m_acc + m_mdr; m_acc = s % 256; m_c = s / 256; end
             if (opc == 3) m_mem[m_mar] = m_mdr;
             m_st = 6;
           end
        6: begin m_pc = (m_pc + 1) % 32; m_st = 0; end
        default: m_st = 7;
      endcase
    end
  end

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_on) begin
      check_eq("R2",  "step",  int'(dbg_step), 1 << m_st);
      check_eq("R10", "pc",    int'(dbg_pc),   m_pc);
      check_eq("R3",  "ir",    int'(dbg_ir),   m_ir);
      check_eq("R4",  "mar",   int'(dbg_mar),  m_mar);
      check_eq("R3",  "mdr",   int'(dbg_mdr),  m_mdr);
      check_eq("R5",  "acc",   int'(dbg_acc),  m_acc);
      check_eq("R12", "carry", int'(dbg_carry), m_c);
    end
  end

  always @(negedge clk) begin
    if (cycles > 20000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
      finish_run();
    end
  end

  task automatic put_word(int a, int d);
    load_en = 1'b1; load_addr = 5'(a); load_data = 8'(d);
    m_mem[a] = d;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic wait_pc(int n);
    while (int'(dbg_pc) != n) @(negedge clk);
  endtask

  task automatic check_reset_state(string tag);
    check_eq("R1", {tag, " pc"},    int'(dbg_pc), 0);
    check_eq("R1", {tag, " ir"},    int'(dbg_ir), 0);
    check_eq("R1", {tag, " mar"},   int'(dbg_mar), 0);
    check_eq("R1", {tag, " mdr"},   int'(dbg_mdr), 0);
    check_eq("R1", {tag, " acc"},   int'(dbg_acc), 0);
    check_eq("R1", {tag, " carry"}, int'(dbg_carry), 0);
    check_eq("R1", {tag, " step"},  int'(dbg_step), 1);
  endtask

  initial begin
    // program 1: trace, store, carry and halt
    rst = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 32; i++) begin
      int w;
      case (i)
        6:  w = 8'h4F;  // load 15
        7:  w = 8'hB2;  // add 18
        8:  w = 8'h73;  // store 19
        10: w = 8'h53;  // load 19
        11: w = 8'hB4;  // add 20
        12: w = 8'h3F;  // no-op opcode 001
        13: w = 8'h4F;  // load 15
        14: w = 8'hFF;  // halt
        15: w = 10;
        18: w = 71;
        20: w = 200;
        default: w = 0;
      endcase
      put_word(i, w);
    end
    check_reset_state("r1_initial");
    cmp_on = 1;
    rst = 1'b0;

    wait_pc(7);
    check_eq("R11", "acc after load at 6", int'(dbg_acc), 8'b0000_1010);
    check_eq("R4",  "ir holds load word", int'(dbg_ir), 8'h4F);
    check_eq("R4",  "mar holds operand 15", int'(dbg_mar), 15);
    wait_pc(8);
    check_eq("R11", "acc after add at 7", int'(dbg_acc), 8'b0101_0001);
    check_eq("R6",  "carry clear for 10+71", int'(dbg_carry), 0);
    wait_pc(9);
    check_eq("R7",  "acc kept by store", int'(dbg_acc), 8'h51);
    check_eq("R7",  "mdr holds stored value", int'(dbg_mdr), 8'h51);
    wait_pc(11);
    check_eq("R7",  "stored word read back", int'(dbg_acc), 8'h51);
    wait_pc(12);
    check_eq("R6",  "acc 81+200 mod 256", int'(dbg_acc), 25);
    check_eq("R6",  "carry out of 81+200", int'(dbg_carry), 1);
    wait_pc(13);
    check_eq("R9",  "no-op 001 keeps acc", int'(dbg_acc), 25);
    wait_pc(14);
    check_eq("R12", "carry kept across load", int'(dbg_carry), 1);
    check_eq("R5",  "load of word 15", int'(dbg_acc), 10);
    for (int k = 0; k < 20; k++) @(negedge clk);
    check_eq("R8", "halted step", int'(dbg_step), 8'b1000_0000);
    check_eq("R8", "pc frozen", int'(dbg_pc), 14);
    check_eq("R8", "acc frozen", int'(dbg_acc), 10);

    // program 2: mixed no-op opcodes and program counter wrap
    rst = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 32; i++) begin
      int w;
      int ops [4] = '{0, 1, 4, 6};
      if (i == 0)       w = 8'h5F;  // load 31
      else if (i == 31) w = 8'h11;
      else              w = ops[i % 4] * 32 + i;
      put_word(i, w);
    end
    check_reset_state("r1_program2");
    rst = 1'b0;
    wait_pc(31);
    check_eq("R9",  "acc after no-op run", int'(dbg_acc), 8'h11);
    check_eq("R9",  "carry after no-op run", int'(dbg_carry), 0);
    wait_pc(0);
    check_eq("R10", "pc wrapped to 0", int'(dbg_pc), 0);
    check_eq("R10", "step at fetch after wrap", int'(dbg_step), 1);

    // reset in the middle of an instruction
    for (int k = 0; k < 10; k++) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check_reset_state("r1_midrun");
    rst = 1'b0;
    for (int k = 0; k < 8; k++) @(negedge clk);
    check_eq("R10", "pc after one instruction from reset", int'(dbg_pc), 1);

    finish_run();
  end
endmodule